// File: doc/BRIEF.md
# Eight-Entry Memory-Mapped Receive Byte Buffer

This block collects bytes handed over by a serial receiver and presents them to a processor through four 32-bit registers. The receiver delivers a byte with a one-cycle valid strobe. The buffer stores the byte at a write position and increments a length count. A bus read of the receive-data word returns the oldest byte and removes it from the buffer. The buffer keeps no read pointer. The read slot is the write position minus the length, modulo eight. When all eight slots are full, further arriving bytes are discarded.

A control register stores a software-written value. One of its bits empties the buffer, and another enables the interrupt request. A status register reports whether data is waiting and whether the buffer is full. Writes to the transmit word are passed straight out as a one-cycle byte strobe for a transmitter outside this block.

Top module: `rxq_mmio`

## Requirements
- R1: After reset the length and write position are zero, the control word reads 0, the status word reads 0, and `irq` and `tx_strobe` are low.
- R2: A byte arriving with `rx_valid` while fewer than 8 bytes are held is stored at the write position. The position then advances and wraps from 7 back to 0, and the length grows by one.
- R3: A byte arriving while 8 bytes are held is dropped. The stored bytes, their order and the full status stay unchanged.
- R4: The bus address is a byte offset, and bits [3:2] select the word: 0x0 receive data, 0x4 transmit, 0x8 status, 0xC control. A read of 0x0 returns the byte at (position − length) mod 8 in bits [7:0], with zero above. If the length is non-zero, the read removes that byte.
- R5: A read of 0x0 while the buffer is empty returns the byte last stored in the slot at the write position, or 0 if that slot was never written since reset. The length stays 0.
- R6: An arriving byte and a removing read in the same cycle both take effect. When the buffer is full, the arriving byte is still dropped.
- R7: A write to 0xC stores all 32 bits, and a read of 0xC returns the stored value. If bit 0 of the written value is 1, the length and write position both become 0. This clearing takes priority over an arriving byte and a read in the same cycle.
- R8: Writes to 0x8 (status) and to 0x0 (receive data) change nothing.
- R9: A write to 0x4 makes `tx_strobe` high for exactly the next cycle, with `tx_byte` equal to bits [7:0] of the written data. A read of 0x4 returns 0.
- R10: The status word has bit 0 set when the length is non-zero and bit 1 set when the length equals 8. All other bits are 0.
- R11: `irq` is high exactly when control bit 4 is set and either status bit 0 is set or `tx_strobe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wr | input | 1 | Register write this cycle |
| bus_rd | input | 1 | Register read this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| tx_strobe | output | 1 | One-cycle transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
Several conditions are hard to reach from the ports. One is a full buffer meeting an arriving byte and a removing read in the same cycle. Another is an empty read after the write position has wrapped or been cleared, which returns a leftover byte from an earlier pass. The stimulus fills the buffer to eight, fires the combined push and read, and drains it. It then empties the buffer with the control bit and reads again. A long random phase follows, mixing flushes, reads and arrivals, so that the position wraps many times while a behavioural model tracks each slot's last byte.

// File: rtl/rxq_mmio.sv
module rxq_mmio #(
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_strobe,
  output logic [7:0]  tx_byte,
  output logic        irq
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int LEN_W  = IDX_W + 1;
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_RX   = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_TX   = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_STAT = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_CTRL = WORD_W'(3);

  logic [7:0]       mem [DEPTH];
  logic [IDX_W-1:0] pos_q;
  logic [LEN_W-1:0] len_q;
  logic [31:0]      ctrl_q;
  logic             tx_q;
  logic [7:0]       txb_q;

  wire [WORD_W-1:0] word = bus_addr[ADDR_W-1:2];
  wire unused_lo = &{1'b0, bus_addr[1:0]};

  wire has_data = len_q != '0;
  wire is_full  = len_q == LEN_W'(DEPTH);
  wire wr_ctrl  = bus_wr && word == W_CTRL;
  wire flush    = wr_ctrl && bus_wdata[0];
  wire pop      = bus_rd && word == W_RX && has_data && !flush;
  wire push     = rx_valid && !is_full && !flush;

  wire [IDX_W-1:0] rd_idx = pos_q - len_q[IDX_W-1:0];
  wire [31:0] status = {30'd0, is_full, has_data};

  always_comb begin
    case (word)
      W_RX:    bus_rdata = {24'd0, mem[rd_idx]};
      W_STAT:  bus_rdata = status;
      W_CTRL:  bus_rdata = ctrl_q;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[pos_q] <= rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      len_q <= '0;
    end else if (flush) begin
      pos_q <= '0;
      len_q <= '0;
    end else begin
      if (push) pos_q <= pos_q + 1'b1;
      case ({push, pop})
        2'b10:   len_q <= len_q + 1'b1;
        2'b01:   len_q <= len_q - 1'b1;
        default: len_q <= len_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tx_q   <= 1'b0;
      txb_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      tx_q <= bus_wr && word == W_TX;
      if (bus_wr && word == W_TX) txb_q <= bus_wdata[7:0];
    end
  end

  assign tx_strobe = tx_q;
  assign tx_byte   = txb_q;
  assign irq       = ctrl_q[4] && (has_data || tx_q);
endmodule

// File: rtl/rxq_mmio_chk.sv
module rxq_mmio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] word,
  input logic [7:0] wbyte,
  input logic [1:0] stat,
  input logic       tx_strobe,
  input logic [7:0] tx_byte,
  input logic       irq,
  input logic [3:0] len,
  input logic [2:0] pos
);
  wire c_flush = bus_wr && word == 2'd3 && wbyte[0];
  wire c_pop   = bus_rd && word == 2'd0 && len != 4'd0;

  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    len <= 4'd8);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (len == 4'd8 && rx_valid && !c_pop && !c_flush) |=> (len == 4'd8 && $stable(pos)));

  p_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && len < 4'd8 && !c_pop && !c_flush) |=>
      (len == $past(len) + 4'd1 && pos == $past(pos) + 3'd1));

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && word == 2'd0 && len == 4'd0 && !rx_valid) |=> len == 4'd0);

  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    c_flush |=> (len == 4'd0 && pos == 3'd0));

  p_tx_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word == 2'd1) |=> (tx_strobe && tx_byte == $past(wbyte)));

  p_tx_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && word == 2'd1) |=> !tx_strobe);

  p_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[1] |-> stat[0]) && (stat[0] == (len != 4'd0)));

  p_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat[0] || tx_strobe));
endmodule

bind rxq_mmio rxq_mmio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .word(word), .wbyte(bus_wdata[7:0]), .stat(status[1:0]), .tx_strobe(tx_strobe),
  .tx_byte(tx_byte), .irq(irq), .len(len_q), .pos(pos_q)
);

// File: tb/tb_rxq_mmio.sv
module tb_rxq_mmio;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] rx_byte = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic tx_strobe, irq;
  logic [7:0] tx_byte;

  rxq_mmio dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  byte unsigned q[$];
  byte unsigned sh[8];
  int pos = 0;
  logic [31:0] m_ctrl = 0;
  bit m_tx = 0;
  byte unsigned m_txb = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(int w);
    case (w)
      0: return q.size() > 0 ? 32'(q[0]) : 32'(sh[pos]);
      2: return {30'd0, q.size() == 8, q.size() != 0};
      3: return m_ctrl;
      default: return 32'd0;
    endcase
  endfunction

  task automatic step(bit rv, byte unsigned rb, bit wr, bit rd, int w, logic [31:0] wd, string tag);
    bit flush, full;
    @(negedge clk);
    rx_valid = rv; rx_byte = rb; bus_wr = wr; bus_rd = rd;
    bus_addr = 4'(w * 4); bus_wdata = wd;
    #1;
    if (rd) chk(tag, bus_rdata, exp_read(w));
    chk("R9 tx_strobe", 32'(tx_strobe), 32'(m_tx));
    if (m_tx) chk("R9 tx_byte", 32'(tx_byte), 32'(m_txb));
    chk("R11 irq", 32'(irq), 32'(m_ctrl[4] && (q.size() != 0 || m_tx)));
    @(posedge clk);
    flush = wr && w == 3 && wd[0];
    full = q.size() == 8;
    if (wr && w == 3) m_ctrl = wd;
    m_tx = wr && w == 1;
    if (m_tx) m_txb = wd[7:0];
    if (flush) begin
      q.delete(); pos = 0;
    end else begin
      if (rd && w == 0 && q.size() > 0) void'(q.pop_front());
      if (rv && !full) begin
        sh[pos] = rb; q.push_back(rb); pos = (pos + 1) % 8;
      end
    end
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, ""); endtask
  task automatic push(byte unsigned b); step(1, b, 0, 0, 0, 0, ""); endtask
  task automatic rd(int w, string tag); step(0, 0, 0, 1, w, 0, tag); endtask
  task automatic wr(int w, logic [31:0] d); step(0, 0, 1, 0, w, d, ""); endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    foreach (sh[i]) sh[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    #1;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 tx_strobe", 32'(tx_strobe), 0);
    rd(2, "R1 status"); rd(3, "R1 ctrl"); rd(0, "R1 R5 empty data");
    // R2 R4 R10 basic fill and drain
    push(8'h11); push(8'h22); push(8'h33);
    rd(2, "R10 status partial");
    rd(0, "R4 oldest"); rd(0, "R4 second"); rd(0, "R4 third");
    rd(2, "R10 status empty");
    rd(0, "R5 empty stale"); rd(0, "R5 empty again");
    // R3 fill to eight then overflow
    for (int i = 0; i < 8; i++) push(8'hA0 + 8'(i));
    rd(2, "R10 status full");
    push(8'hEE); push(8'hEF);
    rd(2, "R3 still full");
    // R6 push and pop together at full: push dropped
    step(1, 8'h5A, 0, 1, 0, 0, "R6 pop at full");
    rd(2, "R6 status after");
    // R6 push and pop together below full
    step(1, 8'h5B, 0, 1, 0, 0, "R6 pop with push");
    for (int i = 0; i < 8; i++) rd(0, "R2 R3 drain order");
    rd(0, "R5 empty after wrap");
    // R7 flush with data and stored control
    push(8'h01); push(8'h02);
    wr(3, 32'hCAFE_0011);
    rd(3, "R7 ctrl readback"); rd(2, "R7 status after flush");
    rd(0, "R5 R7 stale after flush");
    step(1, 8'h77, 1, 1, 3, 32'h0000_0001, "R7 flush beats push");
    rd(2, "R7 status after flush race");
    wr(3, 32'h0000_0010);
    // R8 writes to status and data words ignored
    push(8'h44);
    wr(2, 32'hFFFF_FFFF); wr(0, 32'h0000_00FF);
    rd(2, "R8 status unchanged"); rd(0, "R8 data unchanged");
    // R9 R11 transmit strobe and irq
    wr(1, 32'h1234_56C3); idle(); idle();
    rd(1, "R9 tx read zero");
    wr(3, 32'h0); wr(1, 32'h99); idle();
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int w = $urandom % 4;
      bit b_wr = ($urandom % 6) == 0;
      logic [31:0] d = $urandom;
      if (w == 3 && ($urandom % 4) != 0) d[0] = 0;
      if (b_wr) step($urandom % 2, 8'($urandom), 1, 0, w, d, "");
      else begin
        bit b_rd = $urandom % 2;
        string t = w == 0 ? (q.size() > 0 ? "R4 rand" : "R5 rand") :
                   w == 2 ? "R10 rand" : w == 3 ? "R7 rand" : "R9 rand";
        step($urandom % 2, 8'($urandom), 0, b_rd, w, 0, t);
      end
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule